// File: doc/BRIEF.md
# Receive Frame Queue

This block is the host-side receive buffer of an Ethernet MAC. Bytes arriving from the MAC are packed four to a 32-bit word and stored in a data FIFO. When the last byte of a frame arrives, one status word is queued in a separate command FIFO. That word holds the byte length of the frame and sixteen flag bits supplied by the MAC. The host learns how many frames are waiting from the upper half of a combined count word. It then pops one status word and reads that frame as whole 32-bit words.

The number of waiting frames drives an almost-full indication against a programmable level. Each FIFO has its own sticky overflow flag. A flush input empties both queues and drops incoming bytes for as long as it is held. Both FIFOs use a registered read port, so each pop returns its word one clock later.

Top module: `rx_frame_queue`

## Requirements
- R1: A status word has the frame length in bytes in bits 15:0 and the flag value presented with the last byte in bits 31:16.
- R2: `cmd_bad` is 1 exactly when the status word on `cmd_word` has any bit set under the mask 32'hDF180000.
- R3: `word_count` bits 31:16 give the number of queued status words and bits 15:0 give the number of queued data words. Both are 0 after reset.
- R4: Byte k of a frame is placed in bits 8*(k mod 4)+7 to 8*(k mod 4) of data word k/4. The last word of a frame is zero-padded, so a frame occupies ceil(length/4) words.
- R5: A frame is counted in `word_count[31:16]` in the same cycle as its last data word, two clocks after its last byte is accepted, and never earlier.
- R6: A pop presents the head entry on `cmd_word` or `data_word` one clock later. A pop while that queue is empty has no effect on the output or on the counts.
- R7: One clock after the frame count is at or above a nonzero `af_level`, `cmd_almost_full` is 1; a level of 0 keeps it at 0.
- R8: A frame that ends while the command FIFO is full loses its status word, and `cmd_overflow` is set and stays set.
- R9: A data word written while the data FIFO is full is dropped, and `data_overflow` is set and stays set.
- R10: While `flush` is 1 both FIFOs are emptied, both overflow flags are cleared, incoming bytes are ignored, and a partly received frame is discarded.
- R11: After reset `cmd_almost_full`, `cmd_overflow` and `data_overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty both queues while held |
| in_valid | input | 1 | Byte strobe from the MAC |
| in_byte | input | 8 | Received byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_flags | input | 16 | Frame flags, taken with the final byte |
| af_level | input | 16 | Almost-full frame level, 0 disables |
| cmd_pop | input | 1 | Pop one status word |
| cmd_word | output | 32 | Popped status word |
| cmd_bad | output | 1 | Popped status word marks a bad frame |
| data_pop | input | 1 | Pop one data word |
| data_word | output | 32 | Popped data word |
| word_count | output | 32 | Queued frames (31:16) and data words (15:0) |
| cmd_almost_full | output | 1 | Frame count reached the level |
| cmd_overflow | output | 1 | Sticky command FIFO overflow |
| data_overflow | output | 1 | Sticky data FIFO overflow |

## Verification
The bench builds the block with an 8-word data FIFO and a 4-entry command FIFO. This lets a single 40-byte frame overrun the data queue and five one-byte frames overrun the status queue within a few dozen cycles. With these sizes, the full-queue drop behaviour and the sticky flags can be checked alongside frames of length 1, 3, 5 and 8. The tests also cover a flush in the middle of a frame and the almost-full level being switched on and off.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int LEN_W  = 16;
  localparam int FLAG_W = 16;
  localparam int STAT_W = LEN_W + FLAG_W;
  localparam logic [STAT_W-1:0] BAD_MASK = 32'hDF18_0000;

  typedef struct packed {
    logic [FLAG_W-1:0] flags;
    logic [LEN_W-1:0]  len;
  } rxq_status_t;
endpackage

// File: rtl/rxq_sync_fifo.sv
module rxq_sync_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [AW:0]      count,
  output logic             overflow
);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic             do_wr, do_rd, is_full;

  assign is_full  = (count == FULL_CNT);
  assign do_wr    = wr_en && !is_full && !flush;
  assign do_rd    = rd_en && (count != '0) && !flush;
  assign overflow = wr_en && is_full && !flush;

  // storage without reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (do_rd) rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) rp <= rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rxq_byte_packer.sv
module rxq_byte_packer
  import rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              in_last,
  input  logic [FLAG_W-1:0] in_flags,
  output logic              word_we,
  output logic [31:0]       word_out,
  output logic              stat_we,
  output rxq_status_t       stat_out
);
  logic [1:0]       lane;
  logic [23:0]      acc;
  logic [LEN_W-1:0] len;
  logic [31:0]      merged;

  always_comb merged = {8'h00, acc} | ({24'h000000, in_byte} << {lane, 3'b000});

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      lane     <= '0;
      acc      <= '0;
      len      <= '0;
      word_we  <= 1'b0;
      word_out <= '0;
      stat_we  <= 1'b0;
      stat_out <= '0;
    end else begin
      word_we <= 1'b0;
      stat_we <= 1'b0;
      if (in_valid) begin
        if (lane == 2'd3 || in_last) begin
          word_out <= merged;
          word_we  <= 1'b1;
          acc      <= '0;
          lane     <= in_last ? 2'd0 : lane + 2'd1;
        end else begin
          acc  <= merged[23:0];
          lane <= lane + 2'd1;
        end
        if (in_last) begin
          stat_out.flags <= in_flags;
          stat_out.len   <= len + 1'b1;
          stat_we        <= 1'b1;
          len            <= '0;
        end else begin
          len <= len + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rx_frame_queue.sv
module rx_frame_queue
  import rxq_pkg::*;
#(
  parameter int DATA_DEPTH = 512,
  parameter int CMD_DEPTH  = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        flush,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  input  logic        in_last,
  input  logic [15:0] in_flags,
  input  logic [15:0] af_level,
  input  logic        cmd_pop,
  output logic [31:0] cmd_word,
  output logic        cmd_bad,
  input  logic        data_pop,
  output logic [31:0] data_word,
  output logic [31:0] word_count,
  output logic        cmd_almost_full,
  output logic        cmd_overflow,
  output logic        data_overflow
);
  localparam int DAW = $clog2(DATA_DEPTH);
  localparam int CAW = $clog2(CMD_DEPTH);

  logic        pk_word_we, pk_stat_we;
  logic [31:0] pk_word;
  rxq_status_t pk_stat;
  logic [DAW:0] data_cnt;
  logic [CAW:0] cmd_cnt;
  logic        data_ovf_now, cmd_ovf_now;
  logic [15:0] frames;

  rxq_byte_packer u_packer (
    .clk(clk), .rst(rst), .flush(flush),
    .in_valid(in_valid), .in_byte(in_byte), .in_last(in_last), .in_flags(in_flags),
    .word_we(pk_word_we), .word_out(pk_word),
    .stat_we(pk_stat_we), .stat_out(pk_stat)
  );

  rxq_sync_fifo #(.WIDTH(32), .DEPTH(DATA_DEPTH)) u_data_q (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(pk_word_we), .wr_data(pk_word),
    .rd_en(data_pop), .rd_data(data_word),
    .count(data_cnt), .overflow(data_ovf_now)
  );

  rxq_sync_fifo #(.WIDTH(STAT_W), .DEPTH(CMD_DEPTH)) u_cmd_q (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(pk_stat_we), .wr_data(pk_stat),
    .rd_en(cmd_pop), .rd_data(cmd_word),
    .count(cmd_cnt), .overflow(cmd_ovf_now)
  );

  assign frames     = 16'(cmd_cnt);
  assign word_count = {frames, 16'(data_cnt)};
  assign cmd_bad    = |(cmd_word & BAD_MASK);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cmd_almost_full <= 1'b0;
      cmd_overflow    <= 1'b0;
      data_overflow   <= 1'b0;
    end else begin
      cmd_almost_full <= (af_level != 16'd0) && (frames >= af_level);
      cmd_overflow    <= cmd_overflow  | cmd_ovf_now;
      data_overflow   <= data_overflow | data_ovf_now;
    end
  end
endmodule

// File: rtl/rx_frame_queue_chk.sv
module rx_frame_queue_chk #(
  parameter int DATA_DEPTH = 512,
  parameter int CMD_DEPTH  = 32
) (
  input logic        clk,
  input logic        rst,
  input logic        flush,
  input logic [15:0] af_level,
  input logic        data_pop,
  input logic [31:0] data_word,
  input logic [31:0] word_count,
  input logic        cmd_almost_full,
  input logic        cmd_overflow,
  input logic        data_overflow
);
  p_af_level_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_almost_full |-> ($past(af_level) != 16'd0 && $past(word_count[31:16]) >= $past(af_level)));

  p_flush_clears_r10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (word_count == 32'd0 && !cmd_overflow && !data_overflow && !cmd_almost_full));

  p_cmd_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_overflow && !flush) |=> cmd_overflow);

  p_data_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (data_overflow && !flush) |=> data_overflow);

  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (32'(word_count[31:16]) <= CMD_DEPTH) && (32'(word_count[15:0]) <= DATA_DEPTH));

  p_frame_step_r5: assert property (@(posedge clk) disable iff (rst)
    !flush |=> (word_count[31:16] == $past(word_count[31:16]) ||
                word_count[31:16] == $past(word_count[31:16]) + 16'd1 ||
                word_count[31:16] + 16'd1 == $past(word_count[31:16])));

  p_empty_pop_r6: assert property (@(posedge clk) disable iff (rst)
    (data_pop && word_count[15:0] == 16'd0) |=> $stable(data_word));
endmodule

bind rx_frame_queue rx_frame_queue_chk #(.DATA_DEPTH(DATA_DEPTH), .CMD_DEPTH(CMD_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .af_level(af_level),
  .data_pop(data_pop), .data_word(data_word), .word_count(word_count),
  .cmd_almost_full(cmd_almost_full), .cmd_overflow(cmd_overflow),
  .data_overflow(data_overflow)
);

// File: tb/rx_frame_queue_test.sv
module rx_frame_queue_test;
  localparam int CLK_PERIOD = 10;
  localparam int DD = 8;
  localparam int CD = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        in_last = 1'b0;
  logic [15:0] in_flags = '0;
  logic [15:0] af_level = '0;
  logic        cmd_pop = 1'b0;
  logic        data_pop = 1'b0;
  logic [31:0] cmd_word, data_word, word_count;
  logic        cmd_bad, cmd_almost_full, cmd_overflow, data_overflow;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_stat[$];
  logic [31:0] exp_words[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_queue #(.DATA_DEPTH(DD), .CMD_DEPTH(CD)) uut (
    .clk(clk), .rst(rst), .flush(flush),
    .in_valid(in_valid), .in_byte(in_byte), .in_last(in_last), .in_flags(in_flags),
    .af_level(af_level), .cmd_pop(cmd_pop), .cmd_word(cmd_word), .cmd_bad(cmd_bad),
    .data_pop(data_pop), .data_word(data_word), .word_count(word_count),
    .cmd_almost_full(cmd_almost_full), .cmd_overflow(cmd_overflow),
    .data_overflow(data_overflow)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: sends bytes and records the expected status and words
  task automatic send_frame(input int len, input logic [15:0] flags, input logic [7:0] seed,
                            input bit keep);
    logic [31:0] w;
    logic [15:0] pre_frames;
    w = '0;
    pre_frames = word_count[31:16];
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = 8'(seed + 8'(i * 7));
      in_last  = (i == len - 1);
      in_flags = flags;
      w = w | ({24'h0, in_byte} << (8 * (i % 4)));
      if ((i % 4) == 3 || i == len - 1) begin
        if (keep) exp_words.push_back(w);
        w = '0;
      end
    end
    if (keep) exp_stat.push_back({flags, 16'(len)});
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    if (keep) check("R5 frame not counted early", 32'(word_count[31:16]), 32'(pre_frames));
    @(negedge clk);
    if (keep) check("R5 frame counted", 32'(word_count[31:16]), 32'(pre_frames) + 1);
  endtask

  // monitor: pops one frame and compares with the scoreboard
  task automatic read_frame();
    logic [31:0] es;
    int nw;
    es = exp_stat.pop_front();
    @(negedge clk); cmd_pop = 1'b1;
    @(negedge clk); cmd_pop = 1'b0;
    check("R1 status word", cmd_word, es);
    check("R2 bad flag", 32'(cmd_bad), 32'(|(es & 32'hDF18_0000)));
    nw = (int'(es[15:0]) + 3) / 4;
    for (int k = 0; k < nw; k++) begin
      @(negedge clk); data_pop = 1'b1;
      @(negedge clk); data_pop = 1'b0;
      check("R4 R6 data word", data_word, exp_words.pop_front());
    end
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); @(negedge clk); flush = 1'b0;
    check("R10 counts cleared", word_count, 32'd0);
    check("R10 flags cleared", {30'd0, cmd_overflow, data_overflow}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 reset count R3", word_count, 32'd0);
    check("R11 reset flags", {29'd0, cmd_almost_full, cmd_overflow, data_overflow}, 32'd0);

    // basic frames, various lengths and flag patterns
    send_frame(5, 16'h0000, 8'h10, 1'b1);
    check("R3 R4 count after len 5", word_count, {16'd1, 16'd2});
    read_frame();
    send_frame(8, 16'h2000, 8'h40, 1'b1);
    read_frame();
    send_frame(1, 16'h0008, 8'hA5, 1'b1);
    read_frame();
    send_frame(3, 16'h0010, 8'h03, 1'b1);
    read_frame();
    check("R3 empty after reads", word_count, 32'd0);

    // almost-full level
    af_level = 16'd2;
    send_frame(5, 16'h0000, 8'h21, 1'b1);
    @(negedge clk);
    check("R7 below level", 32'(cmd_almost_full), 32'd0);
    send_frame(3, 16'h8000, 8'h77, 1'b1);
    @(negedge clk);
    check("R7 at level", 32'(cmd_almost_full), 32'd1);
    check("R3 two frames", word_count, {16'd2, 16'd3});
    af_level = 16'd0;
    @(negedge clk); @(negedge clk);
    check("R7 level zero disables", 32'(cmd_almost_full), 32'd0);
    read_frame();
    read_frame();

    // pop on empty
    held = data_word;
    @(negedge clk); data_pop = 1'b1; cmd_pop = 1'b1;
    @(negedge clk); data_pop = 1'b0; cmd_pop = 1'b0;
    check("R6 empty pop keeps data", data_word, held);
    check("R6 empty pop keeps count", word_count, 32'd0);

    // data overflow: 40 bytes into 8 words
    send_frame(40, 16'h0000, 8'h01, 1'b0);
    check("R9 data kept up to depth", word_count, {16'd1, 16'd8});
    check("R9 data overflow flag", 32'(data_overflow), 32'd1);
    repeat (3) @(negedge clk);
    check("R9 flag sticky", 32'(data_overflow), 32'd1);
    do_flush();

    // command overflow: five one-byte frames into four entries
    for (int f = 0; f < 5; f++) send_frame(1, 16'h0000, 8'(f), 1'b0);
    check("R8 status dropped", word_count, {16'd4, 16'd5});
    check("R8 cmd overflow flag", 32'(cmd_overflow), 32'd1);
    check("R8 data flag untouched", 32'(data_overflow), 32'd0);
    do_flush();

    // flush in the middle of a frame
    @(negedge clk); in_valid = 1'b1; in_byte = 8'hEE; in_last = 1'b0;
    @(negedge clk); in_byte = 8'hDD;
    @(negedge clk); in_valid = 1'b0; flush = 1'b1;
    @(negedge clk); in_valid = 1'b1; in_byte = 8'hCC; in_last = 1'b1;
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0; flush = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R10 input ignored during flush", word_count, 32'd0);
    send_frame(1, 16'h0000, 8'h5A, 1'b1);
    read_frame();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule